// File: doc/BRIEF.md
# Gate Enable and Load-Fault Controller

This block drives the gate-enable lines of a bank of low-side power switches. Each channel has two command sources. One is a bit from the serial command register, which lives outside this block. The other is a parallel input pin that acts on the gate with no clock involved. A channel is on when either source asks for it.

Each channel also has a digital drain-comparator flag. The block reads that flag according to the channel's command state. When the channel is commanded on, a high flag means a shorted load, and the flag must stay high for a deglitch window before the short is reported. When the channel is commanded off, a high flag means an open load. A channel with a load fault does not latch off. Instead, its gate follows a low-duty PWM waveform for as long as the fault lasts.

A battery over-voltage or under-voltage flag turns every gate off and raises a battery fault output. While the battery fault is present, it also masks load-fault reporting. The per-channel fault bits are meant to be loaded into the serial fault register. The combined fault output goes to the controller.

Top module: `gate_fault_ctrl`

## Requirements
- R1: The command for a channel is the OR of its serial bit and its parallel bit. A parallel bit of 0 never turns off a channel whose serial bit is 1.
- R2: A change on a parallel input appears on the gate output in the same cycle, before any clock edge.
- R3: A commanded-off channel whose drain flag is high at a clock edge shows its load-fault bit from that edge on. The bit clears at the first edge where that condition is no longer true.
- R4: A commanded-on channel reports a short only after its drain flag has been high at DEGLITCH consecutive clock edges (default 16). Any edge with the flag low restarts the count.
- R5: While a channel's load-fault bit is 1, its gate output is 1 only during the first PWM_PERIOD/16 counts of a shared counter. That counter runs from 0 to PWM_PERIOD-1 (default 64) and starts at 0 after reset.
- R6: While batt_ov or batt_uv is 1, every gate output is 0 and batt_fault is 1, whatever the commands are.
- R7: A battery fault forces all load-fault bits to 0 at once and clears the short deglitch counts. After the battery fault clears, detection starts again from zero.
- R8: While rst_n is 0, the gate, load-fault, battery-fault and combined fault outputs are all 0. The edge where rst_n is low restarts the PWM counter.
- R9: any_fault is 1 exactly when some load-fault bit is 1 or the battery fault is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; also masks all outputs |
| ser_cmd | input | NCH | Serial command bits, one per channel |
| par_in | input | NCH | Parallel enable pins, one per channel |
| drain_flag | input | NCH | Drain comparator result, one per channel |
| batt_ov | input | 1 | Battery over-voltage flag |
| batt_uv | input | 1 | Battery under-voltage flag |
| gate | output | NCH | Gate enable outputs |
| load_fault | output | NCH | Per-channel load-fault bits for the serial fault register |
| batt_fault | output | 1 | Battery fault flag |
| any_fault | output | 1 | Combined fault flag |

## Verification
On every cycle, the assertions check four things. The PWM counter wraps correctly. A faulted gate is high only in the PWM high window. A short is flagged only after the drain condition held at the previous edge, and an open load only on a commanded-off channel. One cycle of battery fault leaves no raw load fault standing. The exact deglitch length and the restart after a dropout are shown only by the bench scenarios. So are the same-cycle parallel path, the priority between battery, reset and fault, and the recovery after a battery fault clears.

// File: rtl/gfc_pkg.sv
// Package: shared types for the gate/fault controller.
// Assumes: nothing beyond IEEE 1800-2017.
package gfc_pkg;

    // Raw per-channel load-fault status before battery masking
    typedef struct packed {
        logic shorted;
        logic open_ld;
    } chan_fault_t;

endpackage

// File: rtl/gfc_pwm_gen.sv
// Module: gfc_pwm_gen
// Free-running counter shared by all channels. It produces the low-duty
// fault waveform, high for the first PERIOD/16 counts of each period.
// Assumes PERIOD >= 16 so that the high window is at least one count.
module gfc_pwm_gen #(
    parameter int PERIOD = 64
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwm_hi
);
    localparam int CW    = $clog2(PERIOD);
    localparam int ON_CT = PERIOD / 16;

    logic [CW-1:0] cnt_q;

    // Count 0..PERIOD-1 and wrap; restart at 0 on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_q == CW'(PERIOD - 1))
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    // Waveform high during the first ON_CT counts
    always_comb pwm_hi = (cnt_q < CW'(ON_CT));

    a_r5_pwm_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(PERIOD - 1)) |=> (cnt_q == '0));

    a_r5_pwm_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(PERIOD - 1));

endmodule

// File: rtl/gfc_chan.sv
// Module: gfc_chan
// Load-fault detector for one channel. The drain flag is read as a short
// while the channel is commanded on, and it is deglitched over DEGLITCH
// edges. The same flag is read as an open load while the channel is
// commanded off, and that reading is registered once.
// Assumes the drain flag is already synchronous to clk.
module gfc_chan
    import gfc_pkg::*;
#(
    parameter int DEGLITCH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic        drain_i,
    input  logic        batt_i,
    output chan_fault_t fault_o
);
    localparam int DW = $clog2(DEGLITCH + 1);

    logic [DW-1:0] dg_q;
    logic          open_q;
    logic          short_cond;
    logic          open_cond;

    // Decode the comparator meaning from the command state
    always_comb begin
        short_cond = en_i && drain_i && !batt_i;
        open_cond  = !en_i && drain_i && !batt_i;
    end

    // Deglitch counter: saturate at DEGLITCH, restart on any dropout
    always_ff @(posedge clk) begin
        if (!rst_n || !short_cond)
            dg_q <= '0;
        else if (dg_q != DW'(DEGLITCH))
            dg_q <= dg_q + 1'b1;
    end

    // Open-load flag registered once
    always_ff @(posedge clk) begin
        if (!rst_n)
            open_q <= 1'b0;
        else
            open_q <= open_cond;
    end

    // Pack the raw status
    always_comb begin
        fault_o.shorted = (dg_q == DW'(DEGLITCH));
        fault_o.open_ld = open_q;
    end

    // R4: a short only appears after the condition held at the previous edge
    a_r4_short_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o.shorted) |-> $past(short_cond));

    // R3: an open load is only recorded for a commanded-off channel
    a_r3_open_only_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_o.open_ld) |-> $past(!en_i));

endmodule

// File: rtl/gate_fault_ctrl.sv
// Module: gate_fault_ctrl (top)
// Combines the serial and parallel commands, runs one fault detector per
// channel and the shared fault PWM, and applies the battery and reset
// overrides to the gates and the fault outputs.
// Assumes ser_cmd is held by an external serial register. par_in reaches
// the gates through combinational logic only.
module gate_fault_ctrl
    import gfc_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int DEGLITCH   = 16,
    parameter int PWM_PERIOD = 64
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ser_cmd,
    input  logic [NCH-1:0] par_in,
    input  logic [NCH-1:0] drain_flag,
    input  logic           batt_ov,
    input  logic           batt_uv,
    output logic [NCH-1:0] gate,
    output logic [NCH-1:0] load_fault,
    output logic           batt_fault,
    output logic           any_fault
);
    logic [NCH-1:0] cmd_en;
    logic [NCH-1:0] raw_fault;
    logic           batt_act;
    logic           pwm_hi;
    chan_fault_t    chan_st [NCH];

    // Merge the command sources and the battery flags
    always_comb begin
        cmd_en   = ser_cmd | par_in;
        batt_act = batt_ov | batt_uv;
    end

    gfc_pwm_gen #(.PERIOD(PWM_PERIOD)) u_pwm (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwm_hi (pwm_hi)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        gfc_chan #(.DEGLITCH(DEGLITCH)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (cmd_en[i]),
            .drain_i (drain_flag[i]),
            .batt_i  (batt_act),
            .fault_o (chan_st[i])
        );

        // Raw fault for this channel, either kind
        always_comb raw_fault[i] = chan_st[i].shorted | chan_st[i].open_ld;

        // Gate select: overrides first, then PWM on fault, then command
        always_comb begin
            if (!rst_n || batt_act)
                gate[i] = 1'b0;
            else if (load_fault[i])
                gate[i] = pwm_hi;
            else
                gate[i] = cmd_en[i];
        end

        // R5: a faulted gate is only high inside the PWM window
        a_r5_fault_pwm: assert property (@(posedge clk) disable iff (!rst_n)
            (load_fault[i] && gate[i]) |-> pwm_hi);
    end

    // Reported faults, masked by battery and reset
    always_comb begin
        load_fault = (rst_n && !batt_act) ? raw_fault : '0;
        batt_fault = rst_n && batt_act;
        any_fault  = (|load_fault) || batt_fault;
    end

    // R7: one edge of battery fault leaves no raw load fault behind
    a_r7_batt_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $past(batt_act) |-> (raw_fault == '0));

    // R6: the battery fault never coexists with a driven gate
    a_r6_batt_gates: assert property (@(posedge clk) disable iff (!rst_n)
        batt_fault |-> (gate == '0));

endmodule

// File: tb/sim_gate_fault_ctrl.sv
module sim_gate_fault_ctrl;
    localparam int NCH = 4;
    localparam int DG  = 16;
    localparam int PER = 64;
    localparam int ON  = PER / 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ser_cmd = '0, par_in = '0, drain_flag = '0;
    logic batt_ov = 1'b0, batt_uv = 1'b0;
    logic [NCH-1:0] gate, load_fault;
    logic batt_fault, any_fault;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    int m_dg [NCH];
    bit m_open [NCH];
    int m_pwm;

    always #4 clk = ~clk;

    gate_fault_ctrl #(.NCH(NCH), .DEGLITCH(DG), .PWM_PERIOD(PER)) u0 (
        .clk(clk), .rst_n(rst_n), .ser_cmd(ser_cmd), .par_in(par_in),
        .drain_flag(drain_flag), .batt_ov(batt_ov), .batt_uv(batt_uv),
        .gate(gate), .load_fault(load_fault), .batt_fault(batt_fault),
        .any_fault(any_fault));

    function automatic logic [NCH-1:0] exp_lf();
        logic [NCH-1:0] r = '0;
        bit batt = batt_ov | batt_uv;
        for (int i = 0; i < NCH; i++)
            r[i] = rst_n && !batt && ((m_dg[i] == DG) || m_open[i]);
        return r;
    endfunction

    function automatic logic [NCH-1:0] exp_gate();
        logic [NCH-1:0] r = '0;
        logic [NCH-1:0] lf = exp_lf();
        logic [NCH-1:0] en = ser_cmd | par_in;
        for (int i = 0; i < NCH; i++)
            if (rst_n && !(batt_ov | batt_uv))
                r[i] = lf[i] ? (m_pwm < ON) : en[i];
        return r;
    endfunction

    task automatic check(string tag);
        logic [NCH-1:0] eg = exp_gate();
        logic [NCH-1:0] el = exp_lf();
        logic eb = rst_n && (batt_ov | batt_uv);
        logic ea = (|el) || eb;
        n_chk++;
        if (gate !== eg || load_fault !== el || batt_fault !== eb || any_fault !== ea) begin
            n_fail++;
            $display("FAIL %s: gate=%b lf=%b bf=%b any=%b expected gate=%b lf=%b bf=%b any=%b",
                     tag, gate, load_fault, batt_fault, any_fault, eg, el, eb, ea);
        end
    endtask

    // advance the model by one clock edge using the current inputs
    task automatic model_edge();
        logic [NCH-1:0] en = ser_cmd | par_in;
        bit batt = batt_ov | batt_uv;
        for (int i = 0; i < NCH; i++) begin
            if (!rst_n) begin
                m_dg[i] = 0; m_open[i] = 0;
            end else begin
                if (en[i] && drain_flag[i] && !batt)
                    m_dg[i] = (m_dg[i] < DG) ? m_dg[i] + 1 : DG;
                else
                    m_dg[i] = 0;
                m_open[i] = !en[i] && drain_flag[i] && !batt;
            end
        end
        m_pwm = !rst_n ? 0 : (m_pwm + 1) % PER;
    endtask

    // one cycle: inputs already set after a negedge; check, then edge
    task automatic step(string tag);
        #1 check(tag);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle(int n, string tag);
        for (int k = 0; k < n; k++) step(tag);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: expired, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < NCH; i++) begin m_dg[i] = 0; m_open[i] = 0; end
        m_pwm = 0;
        @(negedge clk);
        // R8: reset holds every output low despite commands and flags
        ser_cmd = '1; par_in = '1; drain_flag = '1;
        idle(3, "R8 reset");
        ser_cmd = '0; par_in = '0; drain_flag = '0;
        rst_n = 1'b1;
        idle(2, "R8 after reset");

        // R1: parallel 0 does not override serial 1; either source enables
        ser_cmd = 4'b0011; par_in = 4'b0101;
        idle(3, "R1 or-enable");

        // R2: parallel path acts within the cycle
        ser_cmd = '0; par_in = 4'b1000;
        #1 check("R2 par rise");
        par_in = 4'b0010;
        #1 check("R2 par change");
        model_edge();
        @(negedge clk);

        // R4: dropout at DG-1 restarts, then exactly DG edges flags a short
        ser_cmd = 4'b0001; par_in = '0; drain_flag = 4'b0001;
        idle(DG - 1, "R4 pre-deglitch");
        drain_flag = '0;
        idle(1, "R4 dropout");
        drain_flag = 4'b0001;
        idle(DG, "R4 recount");
        idle(PER + 4, "R5 pwm on short");
        // R9: combined flag with a fault present
        idle(1, "R9 any");

        // R3: open load on an off channel, then clears
        drain_flag = 4'b0101; ser_cmd = 4'b0001;
        idle(4, "R3 open load");
        drain_flag = 4'b0001;
        idle(3, "R3 open clear");

        // R6/R7: battery blocks gates and masks faults; detection restarts
        batt_ov = 1'b1;
        idle(5, "R6 batt ov");
        batt_ov = 1'b0; batt_uv = 1'b1;
        idle(3, "R7 batt uv mask");
        batt_uv = 1'b0;
        idle(DG + 3, "R7 resume");
        drain_flag = '0; ser_cmd = '0;
        idle(2, "R9 clear");

        // R8: mid-run reset restarts the PWM counter
        drain_flag = 4'b0010; ser_cmd = 4'b0010;
        idle(DG + 7, "R5 short ch1");
        rst_n = 1'b0;
        idle(2, "R8 mid reset");
        rst_n = 1'b1;
        idle(DG + 10, "R8 pwm restart");

        // R9: constrained random mix with sticky inputs
        for (int k = 0; k < 6000; k++) begin
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(0, 29) == 0) ser_cmd[i] = ~ser_cmd[i];
                if ($urandom_range(0, 29) == 0) par_in[i] = ~par_in[i];
                if ($urandom_range(0, 19) == 0) drain_flag[i] = ~drain_flag[i];
            end
            if ($urandom_range(0, 199) == 0) batt_ov = ~batt_ov;
            if ($urandom_range(0, 199) == 0) batt_uv = ~batt_uv;
            if ($urandom_range(0, 1999) == 0) rst_n = 1'b0;
            else rst_n = 1'b1;
            step("R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule